// File: doc/BRIEF.md
# Transmit Descriptor Poll and Suspend Controller

This block is the sequencing core of a transmit DMA engine that walks a table of buffer descriptors in memory. It holds the address of the current descriptor and reads the descriptor's control word through a request/response memory port. It then checks the word's ownership flag. An owned descriptor is handed to the downstream frame logic. When that logic reports completion, the engine writes the control word back with the ownership flag cleared and steps to the next descriptor. The step is either contiguous or spaced by a programmable gap, and a wrap flag sends the engine back to the table base.

When the engine meets a descriptor it does not own, or when the frame logic reports an underflow, it parks in a suspended state. Only a software poll strobe brings it out again. The poll strobe re-reads the descriptor at the unchanged current address, and the engine resumes or parks again depending on what it finds. A sticky status flag records every not-owned fetch until software clears it.

Top module: `txd_poll_ctrl`

## Requirements
- R1: During and after synchronous reset (`rst` high), the engine is stopped. In this state `cur_addr` equals `table_base`, no read, write-back or processing request is active, and `suspended` and `buf_unavail` are 0.
- R2: A `start_en` pulse while stopped makes the engine issue one descriptor read at `cur_addr`. `rd_req_valid` stays high until `rd_req_ready`, and no further read is issued until `rd_resp_valid` returns.
- R3: A returned control word with bit 31 (owned) set raises `proc_busy`, which stays high until `proc_done`.
- R4: After `proc_done`, a write-back is requested at `cur_addr`. Its data is the fetched word with bit 31 cleared and all other bits kept. The request is held until `wb_ready`.
- R5: When the write-back is accepted, `cur_addr` advances by 4*(DESC_WORDS + `skip_len`) bytes, which is 16 bytes with the defaults and a zero gap. The engine then fetches the descriptor at the new address.
- R6: If the fetched word has bit 30 (wrap) set, the next descriptor address is `table_base` instead.
- R7: A returned word with bit 31 clear sends the engine to the suspended state and sets `buf_unavail`. No write-back is made.
- R8: An `underflow` pulse while `proc_busy` is high suspends the engine. There is no write-back, `cur_addr` is unchanged, and `buf_unavail` is not set.
- R9: A `poll_wr` strobe while suspended re-reads the descriptor at the unchanged `cur_addr`. If that word is owned, the engine leaves suspend and processes it.
- R10: If the re-read word is not owned, the engine returns to suspend and sets `buf_unavail` again.
- R11: `buf_unavail` is sticky. It stays set through later processing and is cleared only by a `bu_clr` pulse.
- R12: A `poll_wr` strobe while the engine is not suspended has no effect: no extra read, and the processing in progress continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_en | input | 1 | Leaves the stopped state |
| table_base | input | AW | Base address of the descriptor table |
| skip_len | input | SKIP_W | Gap between descriptors, in 32-bit words |
| poll_wr | input | 1 | Software poll-demand strobe |
| bu_clr | input | 1 | Write-1-to-clear for `buf_unavail` |
| underflow | input | 1 | Underflow pulse from the frame logic |
| proc_done | input | 1 | Frame logic finished the current descriptor |
| rd_req_valid | output | 1 | Descriptor read request |
| rd_req_ready | input | 1 | Read request accepted |
| rd_addr | output | AW | Read address |
| rd_resp_valid | input | 1 | Read data valid |
| rd_resp_data | input | DW | Returned control word |
| wb_valid | output | 1 | Write-back request |
| wb_ready | input | 1 | Write-back accepted |
| wb_addr | output | AW | Write-back address |
| wb_data | output | DW | Control word with the owned flag cleared |
| proc_busy | output | 1 | Descriptor handed to the frame logic |
| suspended | output | 1 | Engine parked in suspend |
| buf_unavail | output | 1 | Sticky not-owned status |
| cur_addr | output | AW | Current descriptor address |
| next_addr | output | AW | Address the engine steps to after write-back |

## Verification
The hardest case to reach from the ports is a poll that lands while a descriptor is in flight to the frame logic. To get there, the bench holds back its automatic completion responder so that the engine sits in processing indefinitely. It then strobes the poll and later injects underflow in that window. The spacing rule is swept over several gaps with a table that ends in a wrap descriptor. Each pass therefore also ends on a re-read of an already-consumed base descriptor, which exercises the not-owned suspend path with stalled and unstalled memory handshakes.

// File: rtl/txd_pkg.sv
package txd_pkg;
   typedef enum logic [2:0] {
      TXS_STOP  = 3'd0,
      TXS_FREQ  = 3'd1,
      TXS_FWAIT = 3'd2,
      TXS_PROC  = 3'd3,
      TXS_WB    = 3'd4,
      TXS_SUSP  = 3'd5
   } txs_e;
endpackage

// File: rtl/txd_addr_step.sv
module txd_addr_step #(
   parameter int AW         = 32,
   parameter int SKIP_W     = 5,
   parameter int DESC_WORDS = 4
) (
   input  logic [AW-1:0]     cur_addr,
   input  logic [AW-1:0]     base_addr,
   input  logic [SKIP_W-1:0] skip_len,
   input  logic              wrap,
   output logic [AW-1:0]     next_addr
);
   localparam int DESC_BYTES = DESC_WORDS * 4;
   localparam int PAD_W      = AW - SKIP_W - 2;

   logic [AW-1:0] gap_bytes;
   logic [AW-1:0] stride;

   initial begin : prm_chk
      assert (PAD_W > 0) else $error("AW too small for SKIP_W");
      assert (DESC_WORDS > 0) else $error("DESC_WORDS must be positive");
   end

   assign gap_bytes = {{PAD_W{1'b0}}, skip_len, 2'b00};
   assign stride    = AW'(DESC_BYTES) + gap_bytes;
   assign next_addr = wrap ? base_addr : (cur_addr + stride);
endmodule

// File: rtl/txd_flag.sv
module txd_flag (
   input  logic clk,
   input  logic rst,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk) begin
      if (rst)      q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end

   // R11
   flag_set_chk: assert property (@(posedge clk) disable iff (rst)
      set |=> q);
   // R11
   flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!set && !clr) |=> $stable(q));
endmodule

// File: rtl/txd_seq.sv
module txd_seq
   import txd_pkg::*;
#(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int AVAIL_BIT = 31
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start_en,
   input  logic [AW-1:0] table_base,
   input  logic [AW-1:0] next_addr,
   input  logic          poll_wr,
   input  logic          underflow,
   input  logic          proc_done,
   input  logic          rd_req_ready,
   input  logic          rd_resp_valid,
   input  logic [DW-1:0] rd_resp_data,
   input  logic          wb_ready,
   output logic          rd_req_valid,
   output logic          wb_valid,
   output logic          proc_busy,
   output logic          suspended,
   output logic [AW-1:0] cur_addr,
   output logic [DW-1:0] desc_word,
   output logic          unavail_set
);
   txs_e st;

   initial begin : prm_chk
      assert (AVAIL_BIT < DW) else $error("AVAIL_BIT outside word");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st        <= TXS_STOP;
         cur_addr  <= table_base;
         desc_word <= '0;
      end else begin
         case (st)
            TXS_STOP:  if (start_en) st <= TXS_FREQ;
            TXS_FREQ:  if (rd_req_ready) st <= TXS_FWAIT;
            TXS_FWAIT: if (rd_resp_valid) begin
                          desc_word <= rd_resp_data;
                          st <= rd_resp_data[AVAIL_BIT] ? TXS_PROC : TXS_SUSP;
                       end
            TXS_PROC:  if (underflow) st <= TXS_SUSP;
                       else if (proc_done) st <= TXS_WB;
            TXS_WB:    if (wb_ready) begin
                          cur_addr <= next_addr;
                          st <= TXS_FREQ;
                       end
            TXS_SUSP:  if (poll_wr) st <= TXS_FREQ;
            default:   st <= TXS_STOP;
         endcase
      end
   end

   assign rd_req_valid = (st == TXS_FREQ);
   assign wb_valid     = (st == TXS_WB);
   assign proc_busy    = (st == TXS_PROC);
   assign suspended    = (st == TXS_SUSP);
   assign unavail_set  = (st == TXS_FWAIT) && rd_resp_valid && !rd_resp_data[AVAIL_BIT];

   // R2
   rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(cur_addr)));
   // R2
   rd_single_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_req_valid && rd_req_ready) |=> !rd_req_valid);
   // R5
   step_chk: assert property (@(posedge clk) disable iff (rst)
      (wb_valid && wb_ready) |=> (cur_addr == $past(next_addr)));
   // R7
   unavail_susp_chk: assert property (@(posedge clk) disable iff (rst)
      unavail_set |=> suspended);
   // R8
   underflow_chk: assert property (@(posedge clk) disable iff (rst)
      (proc_busy && underflow) |=> (suspended && !wb_valid && $stable(cur_addr)));
   // R9
   poll_chk: assert property (@(posedge clk) disable iff (rst)
      (suspended && poll_wr) |=> (rd_req_valid && $stable(cur_addr)));
   // R12
   poll_ignore_chk: assert property (@(posedge clk) disable iff (rst)
      (proc_busy && poll_wr && !underflow && !proc_done) |=> proc_busy);
endmodule

// File: rtl/txd_poll_ctrl.sv
module txd_poll_ctrl #(
   parameter int AW         = 32,
   parameter int DW         = 32,
   parameter int SKIP_W     = 5,
   parameter int DESC_WORDS = 4,
   parameter int AVAIL_BIT  = 31,
   parameter int WRAP_BIT   = 30
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_en,
   input  logic [AW-1:0]     table_base,
   input  logic [SKIP_W-1:0] skip_len,
   input  logic              poll_wr,
   input  logic              bu_clr,
   input  logic              underflow,
   input  logic              proc_done,
   output logic              rd_req_valid,
   input  logic              rd_req_ready,
   output logic [AW-1:0]     rd_addr,
   input  logic              rd_resp_valid,
   input  logic [DW-1:0]     rd_resp_data,
   output logic              wb_valid,
   input  logic              wb_ready,
   output logic [AW-1:0]     wb_addr,
   output logic [DW-1:0]     wb_data,
   output logic              proc_busy,
   output logic              suspended,
   output logic              buf_unavail,
   output logic [AW-1:0]     cur_addr,
   output logic [AW-1:0]     next_addr
);
   localparam logic [DW-1:0] AVAIL_MASK = DW'(1) << AVAIL_BIT;

   logic [DW-1:0] desc_word;
   logic          unavail_set;

   initial begin : prm_chk
      assert (WRAP_BIT < DW && WRAP_BIT != AVAIL_BIT)
         else $error("WRAP_BIT invalid");
   end

   txd_addr_step #(
      .AW(AW), .SKIP_W(SKIP_W), .DESC_WORDS(DESC_WORDS)
   ) u_step (
      .cur_addr  (cur_addr),
      .base_addr (table_base),
      .skip_len  (skip_len),
      .wrap      (desc_word[WRAP_BIT]),
      .next_addr (next_addr)
   );

   txd_seq #(
      .AW(AW), .DW(DW), .AVAIL_BIT(AVAIL_BIT)
   ) u_seq (
      .clk           (clk),
      .rst           (rst),
      .start_en      (start_en),
      .table_base    (table_base),
      .next_addr     (next_addr),
      .poll_wr       (poll_wr),
      .underflow     (underflow),
      .proc_done     (proc_done),
      .rd_req_ready  (rd_req_ready),
      .rd_resp_valid (rd_resp_valid),
      .rd_resp_data  (rd_resp_data),
      .wb_ready      (wb_ready),
      .rd_req_valid  (rd_req_valid),
      .wb_valid      (wb_valid),
      .proc_busy     (proc_busy),
      .suspended     (suspended),
      .cur_addr      (cur_addr),
      .desc_word     (desc_word),
      .unavail_set   (unavail_set)
   );

   txd_flag u_flag (
      .clk (clk),
      .rst (rst),
      .set (unavail_set),
      .clr (bu_clr),
      .q   (buf_unavail)
   );

   assign rd_addr = cur_addr;
   assign wb_addr = cur_addr;
   assign wb_data = desc_word & ~AVAIL_MASK;

   // R4
   wb_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_data) && $stable(wb_addr)));
   // R3
   busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (proc_busy && !proc_done && !underflow) |=> proc_busy);
endmodule

// File: tb/tb_txd_poll_ctrl.sv
module tb_txd_poll_ctrl;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start_en = 1'b0;
   logic [31:0] table_base = 32'h40;
   logic [4:0]  skip_len = '0;
   logic        poll_wr = 1'b0;
   logic        bu_clr = 1'b0;
   logic        underflow = 1'b0;
   logic        proc_done = 1'b0;
   logic        rd_req_valid;
   logic        rd_req_ready = 1'b1;
   logic [31:0] rd_addr;
   logic        rd_resp_valid = 1'b0;
   logic [31:0] rd_resp_data = '0;
   logic        wb_valid;
   logic        wb_ready = 1'b1;
   logic [31:0] wb_addr, wb_data;
   logic        proc_busy, suspended, buf_unavail;
   logic [31:0] cur_addr, next_addr;

   logic [31:0] mem [256];
   logic [31:0] rd_log [16];
   int          rd_cnt, wb_cnt, proc_cnt, pend_cnt;
   logic [31:0] pend_addr;
   logic        stall = 1'b0;
   logic        auto_done = 1'b1;
   int          nchk = 0, nerr = 0;
   bit          finished = 1'b0;

   always #5 clk = ~clk;

   txd_poll_ctrl dut (
      .clk(clk), .rst(rst), .start_en(start_en), .table_base(table_base),
      .skip_len(skip_len), .poll_wr(poll_wr), .bu_clr(bu_clr),
      .underflow(underflow), .proc_done(proc_done),
      .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
      .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
      .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data),
      .proc_busy(proc_busy), .suspended(suspended), .buf_unavail(buf_unavail),
      .cur_addr(cur_addr), .next_addr(next_addr)
   );

   // memory and frame-logic models
   always @(posedge clk) begin
      rd_resp_valid <= 1'b0;
      rd_req_ready  <= stall ? ~rd_req_ready : 1'b1;
      wb_ready      <= stall ? ~wb_ready : 1'b1;
      proc_done     <= auto_done && proc_busy && !proc_done;
      if (rst) begin
         rd_cnt <= 0; wb_cnt <= 0; proc_cnt <= 0; pend_cnt <= 0;
      end else begin
         if (rd_req_valid && rd_req_ready) begin
            rd_log[rd_cnt % 16] <= rd_addr;
            rd_cnt    <= rd_cnt + 1;
            pend_addr <= rd_addr;
            pend_cnt  <= 2;
         end else if (pend_cnt != 0) begin
            pend_cnt <= pend_cnt - 1;
            if (pend_cnt == 1) begin
               rd_resp_valid <= 1'b1;
               rd_resp_data  <= mem[pend_addr[9:2]];
            end
         end
         if (wb_valid && wb_ready) begin
            mem[wb_addr[9:2]] <= wb_data;
            wb_cnt <= wb_cnt + 1;
         end
         if (proc_busy && proc_done) proc_cnt <= proc_cnt + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic pulse(ref logic sig);
      @(negedge clk); sig = 1'b1;
      @(negedge clk); sig = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic wait_susp();
      for (int i = 0; i < 400; i++) begin
         if (suspended) break;
         @(negedge clk);
      end
   endtask

   task automatic wait_busy();
      for (int i = 0; i < 400; i++) begin
         if (proc_busy) break;
         @(negedge clk);
      end
   endtask

   initial begin
      int base_rd, base_wb;
      logic [31:0] stride, last;
      for (int i = 0; i < 256; i++) mem[i] = '0;
      do_reset();
      @(negedge clk);
      // R1 reset state
      chk("R1 cur_addr", cur_addr, 32'h40);
      chk("R1 rd_req_valid", {31'd0, rd_req_valid}, 32'd0);
      chk("R1 wb_valid/proc_busy", {30'd0, wb_valid, proc_busy}, 32'd0);
      chk("R1 suspended/buf_unavail", {30'd0, suspended, buf_unavail}, 32'd0);

      // sweep over gap lengths, with and without handshake stalls
      for (int s = 0; s < 4; s++) begin
         stride = 32'(4 * (4 + s));
         for (int i = 0; i < 256; i++) mem[i] = '0;
         for (int k = 0; k < 3; k++)
            mem[(32'h40 + k * stride) >> 2] = 32'h8000_0100 + k + ((k == 2) ? 32'h4000_0000 : 32'h0);
         skip_len = 5'(s);
         stall = s[0];
         do_reset();
         pulse(start_en);
         wait_susp();
         chk("R2 read count", rd_cnt, 4);
         chk("R2 first read addr", rd_log[0], 32'h40);
         chk("R5 second read addr", rd_log[1], 32'h40 + stride);
         chk("R5 third read addr", rd_log[2], 32'h40 + 2 * stride);
         chk("R6 wrap to base", rd_log[3], 32'h40);
         chk("R3 processed count", proc_cnt, 3);
         chk("R4 write-back count", wb_cnt, 3);
         chk("R4 word1 cleared", mem[(32'h40 + stride) >> 2], 32'h0000_0101);
         chk("R4 word2 cleared, wrap kept", mem[(32'h40 + 2 * stride) >> 2], 32'h4000_0102);
         chk("R7 suspended", {31'd0, suspended}, 32'd1);
         chk("R7 buf_unavail", {31'd0, buf_unavail}, 32'd1);
         chk("R7 cur_addr at base", cur_addr, 32'h40);
      end

      // last sweep left skip=3, stride 28, suspended at base (not owned)
      stall = 1'b0;
      pulse(bu_clr);
      chk("R11 cleared by bu_clr", {31'd0, buf_unavail}, 32'd0);
      repeat (3) @(negedge clk);
      chk("R11 stays clear", {31'd0, buf_unavail}, 32'd0);

      base_rd = rd_cnt; base_wb = wb_cnt;
      pulse(poll_wr);
      wait_susp();
      repeat (6) @(negedge clk);
      chk("R10 one re-read", rd_cnt, base_rd + 1);
      chk("R10 same address", rd_log[base_rd % 16], 32'h40);
      chk("R10 suspended again", {31'd0, suspended}, 32'd1);
      chk("R10 flag set again", {31'd0, buf_unavail}, 32'd1);
      chk("R10 no write-back", wb_cnt, base_wb);

      // owned descriptor, frame logic held busy; flag not cleared
      mem[32'h40 >> 2] = 32'h8000_0111;
      auto_done = 1'b0;
      pulse(poll_wr);
      wait_busy();
      chk("R9 re-read at base", rd_log[(rd_cnt - 1) % 16], 32'h40);
      chk("R9 left suspend", {30'd0, suspended, proc_busy}, 32'd1);
      chk("R11 sticky while running", {31'd0, buf_unavail}, 32'd1);

      base_rd = rd_cnt;
      pulse(poll_wr);
      repeat (5) @(negedge clk);
      chk("R12 no extra read", rd_cnt, base_rd);
      chk("R12 still busy", {31'd0, proc_busy}, 32'd1);

      pulse(bu_clr);
      base_wb = wb_cnt;
      pulse(underflow);
      chk("R8 suspended", {31'd0, suspended}, 32'd1);
      repeat (3) @(negedge clk);
      chk("R8 no write-back", wb_cnt, base_wb);
      chk("R8 cur_addr kept", cur_addr, 32'h40);
      chk("R8 flag not set", {31'd0, buf_unavail}, 32'd0);

      // resume: descriptor still owned, processed, step by 28 into empty slot
      auto_done = 1'b1;
      pulse(poll_wr);
      wait_susp();
      last = mem[32'h40 >> 2];
      chk("R9 processed after poll", wb_cnt, base_wb + 1);
      chk("R4 base word cleared", last, 32'h0000_0111);
      chk("R5 stepped by gap", cur_addr, 32'h40 + 32'd28);
      chk("R7 empty slot flags", {31'd0, buf_unavail}, 32'd1);

      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         nchk++; nerr++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule